// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave side of a byte-addressed serial memory reached over SPI mode 0. A host lowers chip select and shifts an 8-bit instruction in, most significant bit first. The block decodes the instruction from a fixed set of eleven opcodes and then runs the phases that opcode needs: a 16-bit address, data bytes in or data bytes out. It keeps a write-enable latch and a small status register. It gates every modifying command on that latch and clears the latch once such a command completes. It also offers a hold input that freezes a transfer mid-byte, and a deep power-down mode.

All pins are sampled by the block's own system clock. SCK must therefore run well below that clock; the controller finds SCK edges by comparing successive samples. Serial input is captured on rising SCK edges. Serial output changes on falling SCK edges and is driven only while `so_oe` is high. The storage is a small register array (`MEM_BYTES`, default 512). It decodes the low address bits and ignores the upper ones, and an erased or reset byte reads 0xFF. There are no programming delays, so the busy bit always reads 0.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset `so_oe` is low, every storage byte reads 0xFF, and the status byte reads 0x00.
- R2: Opcode 0x03 followed by a 16-bit address returns storage bytes MSB first, starting at that address. The address increments after each byte and wraps from 0xFFFF to 0x0000; only the low log2(MEM_BYTES) address bits select a byte.
- R3: Opcode 0x06 sets the write-enable latch, which is status bit 1, and opcode 0x04 clears it. Each takes effect when chip select rises after exactly 8 bits. Opcode 0x05 returns the status byte repeatedly for as long as clocks continue.
- R4: Opcode 0x02 followed by an address stores each complete data byte. It is ignored when the write-enable latch is clear. The latch clears when chip select rises after at least one byte has been stored.
- R5: Write data stays inside the 128-byte page of the start address: the address after offset 0x7F is offset 0x00 of the same page.
- R6: Opcode 0x01 followed by one byte loads status bits 7, 3 and 2 from that byte and clears the latch. Bits 6:4 and 0 always read 0, and the command is ignored when the latch is clear.
- R7: Opcode 0x42 with an address sets the 128-byte page holding that address to 0xFF when chip select rises after exactly 24 bits, provided the latch is set. It then clears the latch.
- R8: Opcode 0xD8 with an address erases the aligned 256-byte sector holding that address under the same rules as R7.
- R9: Opcode 0xC7 sets all storage to 0xFF when chip select rises after exactly 8 bits, provided the latch is set. It then clears the latch.
- R10: Raising chip select before a full instruction or address has arrived aborts the command with no effect on storage or status.
- R11: An opcode outside the set is ignored, and so is every bit after it, until chip select rises. `so_oe` stays low throughout.
- R12: Opcode 0xB9, completed with exactly 8 bits, enters power-down. There every opcode except 0xAB is ignored. Opcode 0xAB leaves power-down, takes 16 dummy bits, and then returns the signature byte (default 0x5A) repeatedly.
- R13: While `hold_n` is low, SCK edges are ignored, `so_oe` is low and `so` keeps its value. After release the transfer resumes at the same bit.
- R14: `so_oe` is high only in an output phase after its first falling SCK edge, with chip select low and hold inactive. `so` changes only on falling SCK edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the host, mode 0 |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |

## Verification
The hardest case to reach is a hold pause in the middle of a read byte. During the pause SCK keeps toggling, and the block must neither shift nor lose its bit position. The stimulus gets there by stopping a read after three data bits, lowering `hold_n`, and toggling SCK twice with random-looking input. It then releases hold and collects the remaining five bits, and the whole byte must match the stored value. The write-enable gating and the abort paths are reached by raising chip select after partial opcodes or partial addresses. Their effect is then read back through status reads and array reads.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DIN,
        PH_DOUT,
        PH_ARMED,
        PH_SKIP
    } phase_e;

    typedef enum logic [3:0] {
        K_NONE,
        K_READ,
        K_WRITE,
        K_WREN,
        K_WRDI,
        K_RDSR,
        K_WRSR,
        K_PGER,
        K_SECER,
        K_CHER,
        K_WAKE,
        K_SLEEP
    } cmd_e;

    typedef enum logic [1:0] {
        ER_NONE,
        ER_PAGE,
        ER_SECTOR,
        ER_CHIP
    } erase_e;

    function automatic cmd_e decode_op(input logic [7:0] op);
        case (op)
            8'h03:   return K_READ;
            8'h02:   return K_WRITE;
            8'h06:   return K_WREN;
            8'h04:   return K_WRDI;
            8'h05:   return K_RDSR;
            8'h01:   return K_WRSR;
            8'h42:   return K_PGER;
            8'hD8:   return K_SECER;
            8'hC7:   return K_CHER;
            8'hAB:   return K_WAKE;
            8'hB9:   return K_SLEEP;
            default: return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spi_mem_pins.sv
module spi_mem_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_end
);
    typedef struct packed {
        logic sck;
        logic cs_n;
    } pins_t;

    pins_t pin_d, pin_q;

    always_comb begin
        pin_d      = pin_q;
        pin_d.sck  = sck;
        pin_d.cs_n = cs_n;
        sck_rise   = sck & ~pin_q.sck;
        sck_fall   = ~sck & pin_q.sck;
        cs_end     = cs_n & ~pin_q.cs_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q.sck  <= 1'b0;
            pin_q.cs_n <= 1'b1;
        end else begin
            pin_q <= pin_d;
        end
    end
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array
    import spi_mem_pkg::*;
#(
    parameter int MEM_BYTES = 512,
    parameter int PAGE_W    = 7,
    parameter int SECTOR_W  = 8,
    localparam int IDX_W    = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  erase_e           erase,
    output logic [7:0]       rd_data
);
    logic [7:0] cells [MEM_BYTES];

    for (genvar g = 0; g < MEM_BYTES; g++) begin : g_cell
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        logic [7:0] cell_d, cell_q;
        logic       in_page, in_sector;

        always_comb begin
            in_page   = (MY_IDX >> PAGE_W) == (idx >> PAGE_W);
            in_sector = (MY_IDX >> SECTOR_W) == (idx >> SECTOR_W);
            cell_d    = cell_q;
            if (wr_en && idx == MY_IDX) begin
                cell_d = wr_data;
            end else begin
                case (erase)
                    ER_PAGE:   if (in_page)   cell_d = 8'hFF;
                    ER_SECTOR: if (in_sector) cell_d = 8'hFF;
                    ER_CHIP:   cell_d = 8'hFF;
                    default:   ;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cell_q <= 8'hFF;
            else        cell_q <= cell_d;
        end

        assign cells[g] = cell_q;
    end

    assign rd_data = cells[idx];
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          IDX_W     = 9,
    parameter int          PAGE_W    = 7,
    parameter logic [7:0]  SIGNATURE = 8'h5A,
    localparam int         CNT_W     = $clog2(ADDR_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             cs_end,
    input  logic             cs_active,
    input  logic             hold_act,
    input  logic             si,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] mem_idx,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output erase_e           erase,
    output logic             so,
    output logic             so_oe,
    output logic             wel,
    output logic             pd
);
    typedef struct packed {
        phase_e            phase;
        cmd_e              cmd;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        shin;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        shout;
        logic [2:0]        ocnt;
        logic              so;
        logic              oe;
        logic              wel;
        logic [2:0]        prot;
        logic              pd;
        logic              wrote;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [7:0] shin_nx, status, src;
    cmd_e       op;

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        erase   = ER_NONE;
        shin_nx = {st_q.shin[6:0], si};
        op      = decode_op(shin_nx);
        status  = {st_q.prot[2], 3'b000, st_q.prot[1:0], st_q.wel, 1'b0};
        case (st_q.cmd)
            K_RDSR:  src = status;
            K_WAKE:  src = SIGNATURE;
            default: src = rd_data;
        endcase

        if (cs_end) begin
            if (st_q.phase == PH_ARMED) begin
                case (st_q.cmd)
                    K_WREN:  st_d.wel = 1'b1;
                    K_WRDI:  st_d.wel = 1'b0;
                    K_SLEEP: st_d.pd  = 1'b1;
                    K_PGER:  begin erase = ER_PAGE;   st_d.wel = 1'b0; end
                    K_SECER: begin erase = ER_SECTOR; st_d.wel = 1'b0; end
                    K_CHER:  begin erase = ER_CHIP;   st_d.wel = 1'b0; end
                    default: ;
                endcase
            end
            if (st_q.cmd == K_WRITE && st_q.wrote) st_d.wel = 1'b0;
            st_d.phase = PH_CMD;
            st_d.cmd   = K_NONE;
            st_d.cnt   = '0;
            st_d.ocnt  = '0;
            st_d.oe    = 1'b0;
            st_d.wrote = 1'b0;
        end else if (!cs_active) begin
            st_d.phase = PH_CMD;
            st_d.cmd   = K_NONE;
            st_d.cnt   = '0;
            st_d.ocnt  = '0;
            st_d.oe    = 1'b0;
            st_d.wrote = 1'b0;
        end else if (!hold_act) begin
            if (sck_rise) begin
                case (st_q.phase)
                    PH_CMD: begin
                        st_d.shin = shin_nx;
                        st_d.cnt  = st_q.cnt + 1'b1;
                        if (st_q.cnt == CNT_W'(7)) begin
                            st_d.cnt = '0;
                            st_d.cmd = op;
                            if (st_q.pd && op != K_WAKE) begin
                                st_d.phase = PH_SKIP;
                            end else begin
                                case (op)
                                    K_READ:  st_d.phase = PH_ADDR;
                                    K_WAKE:  begin st_d.phase = PH_ADDR; st_d.pd = 1'b0; end
                                    K_WRITE, K_PGER, K_SECER:
                                             st_d.phase = st_q.wel ? PH_ADDR : PH_SKIP;
                                    K_WREN, K_WRDI, K_SLEEP:
                                             st_d.phase = PH_ARMED;
                                    K_CHER:  st_d.phase = st_q.wel ? PH_ARMED : PH_SKIP;
                                    K_RDSR:  st_d.phase = PH_DOUT;
                                    K_WRSR:  st_d.phase = st_q.wel ? PH_DIN : PH_SKIP;
                                    default: st_d.phase = PH_SKIP;
                                endcase
                            end
                        end
                    end
                    PH_ADDR: begin
                        st_d.addr = {st_q.addr[ADDR_W-2:0], si};
                        st_d.cnt  = st_q.cnt + 1'b1;
                        if (st_q.cnt == CNT_W'(ADDR_W - 1)) begin
                            st_d.cnt = '0;
                            case (st_q.cmd)
                                K_READ, K_WAKE: st_d.phase = PH_DOUT;
                                K_WRITE:        st_d.phase = PH_DIN;
                                default:        st_d.phase = PH_ARMED;
                            endcase
                        end
                    end
                    PH_DIN: begin
                        st_d.shin = shin_nx;
                        st_d.cnt  = st_q.cnt + 1'b1;
                        if (st_q.cnt == CNT_W'(7)) begin
                            st_d.cnt = '0;
                            if (st_q.cmd == K_WRITE) begin
                                wr_en      = 1'b1;
                                st_d.wrote = 1'b1;
                                st_d.addr  = {st_q.addr[ADDR_W-1:PAGE_W],
                                              st_q.addr[PAGE_W-1:0] + PAGE_W'(1)};
                            end else begin
                                st_d.prot  = {shin_nx[7], shin_nx[3:2]};
                                st_d.wel   = 1'b0;
                                st_d.phase = PH_SKIP;
                            end
                        end
                    end
                    PH_ARMED: st_d.phase = PH_SKIP;
                    default:  ;
                endcase
            end else if (sck_fall && st_q.phase == PH_DOUT) begin
                st_d.oe   = 1'b1;
                st_d.ocnt = st_q.ocnt + 1'b1;
                if (st_q.ocnt == 3'd0) begin
                    st_d.so    = src[7];
                    st_d.shout = {src[6:0], 1'b0};
                end else begin
                    st_d.so    = st_q.shout[7];
                    st_d.shout = {st_q.shout[6:0], 1'b0};
                end
                if (st_q.ocnt == 3'd7 && st_q.cmd == K_READ) begin
                    st_d.addr = st_q.addr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_CMD;
            st_q.cmd   <= K_NONE;
            st_q.cnt   <= '0;
            st_q.shin  <= '0;
            st_q.addr  <= '0;
            st_q.shout <= '0;
            st_q.ocnt  <= '0;
            st_q.so    <= 1'b0;
            st_q.oe    <= 1'b0;
            st_q.wel   <= 1'b0;
            st_q.prot  <= '0;
            st_q.pd    <= 1'b0;
            st_q.wrote <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_idx = st_q.addr[IDX_W-1:0];
    assign wr_data = shin_nx;
    assign so      = st_q.so;
    assign so_oe   = st_q.oe && st_q.phase == PH_DOUT && cs_active && !hold_act;
    assign wel     = st_q.wel;
    assign pd      = st_q.pd;
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         MEM_BYTES = 512,
    parameter int         PAGE_W    = 7,
    parameter int         SECTOR_W  = 8,
    parameter logic [7:0] SIGNATURE = 8'h5A,
    localparam int        IDX_W     = $clog2(MEM_BYTES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    logic             sck_rise, sck_fall, cs_end;
    logic [IDX_W-1:0] mem_idx;
    logic             wr_en;
    logic [7:0]       wr_data, rd_data;
    erase_e           erase;
    logic             wel, pd;

    spi_mem_pins u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_end   (cs_end)
    );

    spi_mem_ctrl #(
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .PAGE_W    (PAGE_W),
        .SIGNATURE (SIGNATURE)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_end    (cs_end),
        .cs_active (~cs_n),
        .hold_act  (~hold_n),
        .si        (si),
        .rd_data   (rd_data),
        .mem_idx   (mem_idx),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .erase     (erase),
        .so        (so),
        .so_oe     (so_oe),
        .wel       (wel),
        .pd        (pd)
    );

    spi_mem_array #(
        .MEM_BYTES (MEM_BYTES),
        .PAGE_W    (PAGE_W),
        .SECTOR_W  (SECTOR_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (mem_idx),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .erase   (erase),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic cs_n,
    input logic hold_n,
    input logic so,
    input logic so_oe,
    input logic wel,
    input logic pd
);
    logic sck_d, fall_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            sck_d  <= sck;
            fall_q <= sck_d & ~sck;
        end
    end

    assert_oe_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !so_oe);

    assert_so_on_fall_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && !fall_q) |-> $stable(so));

    assert_hold_freeze_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && $past(!hold_n)) |-> ($stable(so) && !so_oe));

    assert_latch_at_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cs_n));

    assert_sleep_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> !so_oe);
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (.*);

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic hold_n = 1'b1;
    logic so, so_oe;

    localparam logic [7:0] SIG = 8'h5A;

    always #2.5 clk = ~clk;

    spi_mem_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .si(si), .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    typedef struct {
        logic [8:0] v;
        string      req;
    } item_t;

    item_t exp_q[$];
    item_t got_q[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // monitor: pairs observed results with predictions
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && got_q.size() > 0) begin
                item_t e, g;
                e = exp_q.pop_front();
                g = got_q.pop_front();
                n_run++;
                if (e.v !== g.v) begin
                    n_fail++;
                    $display("FAIL %s: got oe/data %b_%h expected %b_%h",
                             e.req, g.v[8], g.v[7:0], e.v[8], e.v[7:0]);
                end
            end
        end
    end

    task automatic push(input logic [8:0] expv, input logic [8:0] gotv, input string req);
        item_t e, g;
        e.v = expv; e.req = req;
        g.v = gotv; g.req = req;
        exp_q.push_back(e);
        got_q.push_back(g);
    endtask

    task automatic xbit(input logic b, output logic o, output logic oe);
        @(negedge clk);
        sck = 1'b0;
        si  = b;
        repeat (3) @(negedge clk);
        o  = so;
        oe = so_oe;
        sck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] o,
                         output logic oe_all, output logic oe_any);
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            logic ob, oeb;
            xbit(b[i], ob, oeb);
            o[i]   = ob;
            oe_all = oe_all & oeb;
            oe_any = oe_any | oeb;
        end
    endtask

    task automatic cs_lo();
        @(negedge clk);
        sck = 1'b0;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_hi();
        @(negedge clk);
        sck = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] o;
        logic a, y;
        xbyte(b, o, a, y);
    endtask

    task automatic recv(input logic [7:0] e, input string req);
        logic [7:0] o;
        logic a, y;
        xbyte(8'h00, o, a, y);
        push({1'b1, e}, {a, o}, req);
    endtask

    task automatic recv_silent(input string req);
        logic [7:0] o;
        logic a, y;
        xbyte(8'h00, o, a, y);
        push(9'h000, {y, 8'h00}, req);
    endtask

    task automatic op1(input logic [7:0] op);
        cs_lo(); send(op); cs_hi();
    endtask

    task automatic chk_status(input logic [7:0] e, input string req);
        cs_lo(); send(8'h05); recv(e, req); cs_hi();
    endtask

    task automatic wr1(input logic [15:0] a, input logic [7:0] d);
        cs_lo(); send(8'h02); send(a[15:8]); send(a[7:0]); send(d); cs_hi();
    endtask

    task automatic rd1(input logic [15:0] a, input logic [7:0] e, input string req);
        cs_lo(); send(8'h03); send(a[15:8]); send(a[7:0]); recv(e, req); cs_hi();
    endtask

    task automatic erase_at(input logic [7:0] op, input logic [15:0] a);
        cs_lo(); send(op); send(a[15:8]); send(a[7:0]); cs_hi();
    endtask

    task automatic wrsr(input logic [7:0] v);
        cs_lo(); send(8'h01); send(v); cs_hi();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: idle output and reset status
        push(9'h000, {so_oe, 8'h00}, "R1");
        chk_status(8'h00, "R1");
        rd1(16'h0123, 8'hFF, "R1");

        // R4: write without latch ignored
        wr1(16'h0010, 8'hAA);
        rd1(16'h0010, 8'hFF, "R4");

        // R3: latch set/clear and repeated status
        op1(8'h06);
        cs_lo(); send(8'h05); recv(8'h02, "R3"); recv(8'h02, "R3"); cs_hi();
        op1(8'h04);
        chk_status(8'h00, "R3");

        // R4 / R2: burst write, latch auto-clear, burst read
        op1(8'h06);
        cs_lo(); send(8'h02); send(8'h00); send(8'h20);
        send(8'h11); send(8'h22); send(8'h33); cs_hi();
        chk_status(8'h00, "R4");
        cs_lo(); send(8'h03); send(8'h00); send(8'h20);
        recv(8'h11, "R2"); recv(8'h22, "R2"); recv(8'h33, "R2"); cs_hi();

        // R5: page wrap on write
        op1(8'h06);
        cs_lo(); send(8'h02); send(8'h00); send(8'h7E);
        send(8'hA1); send(8'hA2); send(8'hA3); cs_hi();
        cs_lo(); send(8'h03); send(8'h00); send(8'h7E);
        recv(8'hA1, "R5"); recv(8'hA2, "R5"); recv(8'hFF, "R5"); cs_hi();
        rd1(16'h0000, 8'hA3, "R5");

        // R2: read address wraps 0xFFFF -> 0x0000
        op1(8'h06);
        wr1(16'hFFFF, 8'h5C);
        cs_lo(); send(8'h03); send(8'hFF); send(8'hFF);
        recv(8'h5C, "R2"); recv(8'hA3, "R2"); cs_hi();

        // R6: status write masking and gating
        op1(8'h06); wrsr(8'h8C);
        chk_status(8'h8C, "R6");
        wrsr(8'h00);
        chk_status(8'h8C, "R6");
        op1(8'h06); wrsr(8'hFF);
        chk_status(8'h8C, "R6");
        op1(8'h06); wrsr(8'h00);
        chk_status(8'h00, "R6");

        // R7: page erase
        op1(8'h06);
        erase_at(8'h42, 16'h0020);
        chk_status(8'h00, "R7");
        rd1(16'h0020, 8'hFF, "R7");
        rd1(16'h007E, 8'hFF, "R7");
        rd1(16'hFFFF, 8'h5C, "R7");
        erase_at(8'h42, 16'hFFFF);
        rd1(16'hFFFF, 8'h5C, "R7");

        // R8: sector erase
        op1(8'h06); wr1(16'h0080, 8'h77);
        op1(8'h06); wr1(16'h0100, 8'h88);
        op1(8'h06); erase_at(8'hD8, 16'h0050);
        rd1(16'h0080, 8'hFF, "R8");
        rd1(16'h0100, 8'h88, "R8");

        // R9: chip erase
        op1(8'h06); op1(8'hC7);
        rd1(16'h0100, 8'hFF, "R9");
        rd1(16'hFFFF, 8'hFF, "R9");
        chk_status(8'h00, "R9");

        // R10: aborted address and aborted opcode
        op1(8'h06);
        cs_lo(); send(8'h02); send(8'h00); cs_hi();
        chk_status(8'h02, "R10");
        cs_lo();
        for (int i = 7; i >= 4; i--) begin
            logic o, e;
            xbit(8'h04 >> i, o, e);
        end
        cs_hi();
        chk_status(8'h02, "R10");
        cs_lo(); send(8'h02); send(8'h00); send(8'h30); cs_hi();
        rd1(16'h0030, 8'hFF, "R10");
        op1(8'h04);

        // R11: unknown opcode ignores the rest
        cs_lo(); send(8'h55); send(8'h03); send(8'h00); send(8'h00);
        recv_silent("R11"); cs_hi();
        chk_status(8'h00, "R11");

        // R12: power-down
        op1(8'hB9);
        cs_lo(); send(8'h05); recv_silent("R12"); cs_hi();
        op1(8'h06);
        cs_lo(); send(8'hAB); send(8'h00); send(8'h00);
        recv(SIG, "R12"); recv(SIG, "R12"); cs_hi();
        chk_status(8'h00, "R12");

        // R14: no output enable during address phase
        begin
            logic [7:0] o;
            logic a, y;
            cs_lo(); send(8'h03); send(8'h00);
            xbyte(8'h40, o, a, y);
            push(9'h000, {y, 8'h00}, "R14");
            recv(8'hFF, "R14");
            cs_hi();
        end

        // R13: hold mid-byte during a read
        op1(8'h06); wr1(16'h0040, 8'h3C);
        begin
            logic [7:0] got;
            logic o, e;
            cs_lo(); send(8'h03); send(8'h00); send(8'h40);
            for (int i = 7; i >= 5; i--) begin
                xbit(1'b0, o, e);
                got[i] = o;
            end
            @(negedge clk); hold_n = 1'b0;
            repeat (2) @(negedge clk);
            push(9'h000, {so_oe, 8'h00}, "R13");
            for (int k = 0; k < 2; k++) begin
                sck = 1'b0; si = 1'b1; repeat (4) @(negedge clk);
                sck = 1'b1; si = 1'b0; repeat (4) @(negedge clk);
            end
            hold_n = 1'b1;
            repeat (2) @(negedge clk);
            for (int i = 4; i >= 0; i--) begin
                xbit(1'b0, o, e);
                got[i] = o;
            end
            push({1'b1, 8'h3C}, {1'b1, got}, "R13");
            cs_hi();
        end
        push(9'h000, {so_oe, 8'h00}, "R14");

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule